// File: doc/BRIEF.md
# Angle Counter Output Latch with Busy Handshake

This block keeps the digital angle of a tracking converter in a 16-bit up/down counter and hands it to a host processor over an 8-bit bus. A tracking loop supplies single-cycle count-up and count-down requests. Each accepted request moves the counter at once and starts a positive busy pulse whose width is a cycle-count parameter. Requests that arrive while the pulse is high are dropped.

The host reads a stable angle in two ways. It can pull the active-low hold input low, which freezes the output latch. It can also time its reads around the busy pulse. Two active-low lane enables put the upper or lower byte of the latch onto the bus. A resolution select chooses coarse (14-bit) or fine (16-bit) operation. The select is only taken in on the falling edge of the busy pulse, so a change can never land in the middle of a count. In coarse mode each request moves the counter by four, and the two lowest latch bits read as zero.

Top module: `angle_latch_if`

## Requirements
- R1: While `rst` is high, the counter and the output latch clear to zero, `busy` is 0, and the resolution mode takes the value of `res_coarse`.
- R2: When `busy` is low and exactly one of `cnt_up`/`cnt_dn` is high, the counter changes on that edge and `busy` is 1 after it. The change is +1 or -1 modulo 2^16 in fine mode, and +4 or -4 in coarse mode.
- R3: When `cnt_up` and `cnt_dn` are high together, nothing changes and no busy pulse starts. The counter changes only on an edge where `busy` rises.
- R4: `busy` stays high for exactly `BUSY_CYC` cycles. Count requests that arrive while it is high are ignored.
- R5: The mode is sampled from `res_coarse` (1 = coarse/14-bit, 0 = fine/16-bit) only on the edge where `busy` falls, apart from reset. Changes to `res_coarse` at any other time have no effect.
- R6: In coarse mode, latch bits 1..0 read as 0.
- R7: While `hold_n` is 0, the output latch keeps its value. While `hold_n` is 1, the latch loads the counter, masked for the current mode, on every edge, one cycle behind the counter.
- R8: `hi_oe_n`=0 drives latch bits 15..8 on `data_bus`. With `hi_oe_n`=1 and `lo_oe_n`=0, bits 7..0 are driven. With both high, the bus reads 8'hFF (the released level). When both are low, the upper byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_up | input | 1 | Count-up request from the tracking loop |
| cnt_dn | input | 1 | Count-down request from the tracking loop |
| res_coarse | input | 1 | Resolution select: 1 = 14-bit, 0 = 16-bit |
| hold_n | input | 1 | Active-low freeze of the output latch |
| hi_oe_n | input | 1 | Active-low enable for the upper byte |
| lo_oe_n | input | 1 | Active-low enable for the lower byte |
| data_bus | output | 8 | Selected latch byte, or all ones when released |
| busy | output | 1 | Busy pulse for each counter update |

## Verification
The assertions assume that the count requests, `hold_n`, `res_coarse` and both enables change only between clock edges and are held across each edge. The bench meets this by changing every input on the falling clock edge. The assertions also assume that `BUSY_CYC` is at least 1; the bench shortens the pulse to 12 cycles but keeps it well above that. The random phase sends requests in both directions, including simultaneous up/down requests and requests during busy. It toggles the resolution select both inside and outside busy pulses, and it varies the hold input and the enables in every combination. All inputs stay legal logic levels.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;
  typedef enum logic {
    RES_FINE   = 1'b0,
    RES_COARSE = 1'b1
  } res_mode_e;
endpackage

// File: rtl/busy_timer.sv
module busy_timer
  import angle_latch_pkg::*;
#(
  parameter int BUSY_CYC = 150
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      res_sel,
  output logic      busy_q,
  output res_mode_e mode_q
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      mode_q <= res_mode_e'(res_sel);
    end else if (!busy_q && start) begin
      busy_q <= 1'b1;
      rem_q  <= CW'(BUSY_CYC);
    end else if (busy_q) begin
      if (rem_q == CW'(1)) begin
        busy_q <= 1'b0;
        rem_q  <= '0;
        mode_q <= res_mode_e'(res_sel);
      end else begin
        rem_q <= rem_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/angle_counter.sv
module angle_counter
  import angle_latch_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int DROP    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               dir_up,
  input  res_mode_e          mode,
  output logic [ANGLE_W-1:0] cnt_q
);
  localparam logic [ANGLE_W-1:0] STEP_C = ANGLE_W'(1) << DROP;
  localparam logic [ANGLE_W-1:0] STEP_F = ANGLE_W'(1);

  logic [ANGLE_W-1:0] step;

  always_comb step = (mode == RES_COARSE) ? STEP_C : STEP_F;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= dir_up ? cnt_q + step : cnt_q - step;
  end
endmodule

// File: rtl/out_latch.sv
module out_latch
  import angle_latch_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DROP  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold_n,
  input  res_mode_e            mode,
  input  logic [2*BUS_W-1:0]   cnt,
  input  logic                 hi_oe_n,
  input  logic                 lo_oe_n,
  output logic [BUS_W-1:0]     bus
);
  localparam int ANGLE_W = 2 * BUS_W;
  localparam int LANES   = 2;
  localparam logic [ANGLE_W-1:0] MASK_C = ~((ANGLE_W'(1) << DROP) - ANGLE_W'(1));

  logic [ANGLE_W-1:0] lat_q;
  logic [BUS_W-1:0]   lane [LANES];

  always_ff @(posedge clk) begin
    if (rst)
      lat_q <= '0;
    else if (hold_n)
      lat_q <= (mode == RES_COARSE) ? (cnt & MASK_C) : cnt;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = lat_q[i*BUS_W +: BUS_W];
  end

  always_comb begin
    if (!hi_oe_n)
      bus = lane[1];
    else if (!lo_oe_n)
      bus = lane[0];
    else
      bus = '1;
  end

  // R7: a frozen latch does not move
  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hold_n)) |-> $stable(lat_q));

  // R6: coarse loads never carry fine bits
  a_r6_coarse_low_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold_n) && $past(mode) == RES_COARSE)
      |-> (lat_q[DROP-1:0] == '0));
endmodule

// File: rtl/angle_latch_if.sv
module angle_latch_if
  import angle_latch_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DROP     = 2,
  parameter int BUSY_CYC = 150
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             res_coarse,
  input  logic             hold_n,
  input  logic             hi_oe_n,
  input  logic             lo_oe_n,
  output logic [BUS_W-1:0] data_bus,
  output logic             busy
);
  localparam int ANGLE_W = 2 * BUS_W;

  logic               accept;
  res_mode_e          mode;
  logic [ANGLE_W-1:0] cnt;

  assign accept = (cnt_up ^ cnt_dn) && !busy;

  busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .res_sel(res_coarse),
    .busy_q (busy),
    .mode_q (mode)
  );

  angle_counter #(.ANGLE_W(ANGLE_W), .DROP(DROP)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .dir_up(cnt_up),
    .mode  (mode),
    .cnt_q (cnt)
  );

  out_latch #(.BUS_W(BUS_W), .DROP(DROP)) u_lat (
    .clk    (clk),
    .rst    (rst),
    .hold_n (hold_n),
    .mode   (mode),
    .cnt    (cnt),
    .hi_oe_n(hi_oe_n),
    .lo_oe_n(lo_oe_n),
    .bus    (data_bus)
  );

  // R2: a single request while idle opens a busy pulse
  a_r2_busy_starts: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_up ^ cnt_dn) && !$past(busy)) |-> busy);

  // R3: counter moves only together with a rising busy
  a_r3_count_with_busy: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> $rose(busy));

  // R5: mode changes only when busy falls
  a_r5_mode_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode) |-> $fell(busy));

  // R4: no fresh pulse starts while one is running
  a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(cnt));
endmodule

// File: tb/tb_angle_latch_if.sv
module tb_angle_latch_if;
  localparam int BC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_up = 1'b0, cnt_dn = 1'b0, res_coarse = 1'b0;
  logic hold_n = 1'b1, hi_oe_n = 1'b1, lo_oe_n = 1'b1;
  logic [7:0] data_bus;
  logic busy;

  int n_chk = 0, n_bad = 0;

  angle_latch_if #(.BUS_W(8), .DROP(2), .BUSY_CYC(BC)) dut (
    .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .res_coarse(res_coarse), .hold_n(hold_n), .hi_oe_n(hi_oe_n),
    .lo_oe_n(lo_oe_n), .data_bus(data_bus), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_cnt, m_lat;
  logic m_busy, m_mode;
  int m_rem;

  function automatic logic [15:0] masked(logic [15:0] v, logic md);
    return md ? (v & 16'hFFFC) : v;
  endfunction

  always @(posedge clk) begin
    logic [15:0] n_cnt, n_lat;
    logic n_busy, n_mode, acc;
    int n_rem;
    if (rst) begin
      m_cnt = 0; m_lat = 0; m_busy = 0; m_rem = 0; m_mode = res_coarse;
    end else begin
      n_lat = hold_n ? masked(m_cnt, m_mode) : m_lat;
      acc = (cnt_up ^ cnt_dn) && !m_busy;
      n_cnt = m_cnt; n_busy = m_busy; n_rem = m_rem; n_mode = m_mode;
      if (acc) begin
        n_cnt = cnt_up ? m_cnt + (m_mode ? 16'd4 : 16'd1)
                       : m_cnt - (m_mode ? 16'd4 : 16'd1);
        n_busy = 1; n_rem = BC;
      end else if (m_busy) begin
        if (m_rem == 1) begin n_busy = 0; n_rem = 0; n_mode = res_coarse; end
        else n_rem = m_rem - 1;
      end
      m_cnt = n_cnt; m_lat = n_lat; m_busy = n_busy; m_rem = n_rem; m_mode = n_mode;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      logic [7:0] eb;
      eb = !hi_oe_n ? m_lat[15:8] : (!lo_oe_n ? m_lat[7:0] : 8'hFF);
      chk("R4 busy vs model", {15'd0, busy}, {15'd0, m_busy});
      chk("R8 bus vs model", {8'd0, data_bus}, {8'd0, eb});
    end
  end

  task automatic read_word(output logic [15:0] w);
    @(negedge clk); hi_oe_n = 0; lo_oe_n = 1;
    @(negedge clk); w[15:8] = data_bus; hi_oe_n = 1; lo_oe_n = 0;
    @(negedge clk); w[7:0] = data_bus; lo_oe_n = 1;
  endtask

  task automatic pulse(logic u, logic d);
    @(negedge clk); cnt_up = u; cnt_dn = d;
    @(negedge clk); cnt_up = 0; cnt_dn = 0;
  endtask

  task automatic settle();
    repeat (BC + 3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 busy after reset", {15'd0, busy}, 16'd0);
    read_word(w); chk("R1 latch after reset", w, 16'h0000);
    // R2 fine up
    @(negedge clk); cnt_up = 1;
    @(negedge clk); cnt_up = 0;
    chk("R2 busy rises", {15'd0, busy}, 16'd1);
    settle(); read_word(w); chk("R2 fine up", w, 16'h0001);
    // R3 down wraps
    pulse(0, 1); settle(); pulse(0, 1); settle();
    read_word(w); chk("R3 down wrap", w, 16'hFFFF);
    // R3 both at once
    pulse(1, 1);
    chk("R3 no busy on both", {15'd0, busy}, 16'd0);
    settle(); read_word(w); chk("R3 both ignored", w, 16'hFFFF);
    // R4 request during busy ignored
    pulse(1, 0); repeat (3) @(negedge clk); pulse(1, 0); settle();
    read_word(w); chk("R4 busy drops request", w, 16'h0000);
    // R5/R6 mode capture on trailing edge
    pulse(1, 0); res_coarse = 1; settle();
    read_word(w); chk("R6 coarse masks low bits", w, 16'h0000);
    pulse(1, 0); settle();
    read_word(w); chk("R6 coarse step of four", w, 16'h0004);
    res_coarse = 0; repeat (4) @(negedge clk);
    read_word(w); chk("R5 idle change ignored", w, 16'h0004);
    pulse(1, 0); settle();
    read_word(w); chk("R5 step before capture", w, 16'h0009);
    pulse(1, 0); settle();
    read_word(w); chk("R5 fine after capture", w, 16'h000A);
    // R7 hold
    @(negedge clk); hold_n = 0;
    pulse(1, 0); settle();
    read_word(w); chk("R7 held", w, 16'h000A);
    @(negedge clk); hold_n = 1;
    @(negedge clk);
    read_word(w); chk("R7 released", w, 16'h000B);
    // R8 bus lanes
    @(negedge clk); hi_oe_n = 1; lo_oe_n = 1;
    @(negedge clk); chk("R8 released bus", {8'd0, data_bus}, 16'h00FF);
    hi_oe_n = 0; lo_oe_n = 0;
    @(negedge clk); chk("R8 both low upper wins", {8'd0, data_bus}, 16'h0000);
    hi_oe_n = 1; lo_oe_n = 1;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom % 16;
      cnt_up = (r < 3) || (r == 15);
      cnt_dn = (r >= 3 && r < 5) || (r == 15);
      if ($urandom % 40 == 0) res_coarse = ~res_coarse;
      hold_n  = ($urandom % 4) != 0;
      hi_oe_n = $urandom % 2;
      lo_oe_n = $urandom % 2;
    end
    @(negedge clk); cnt_up = 0; cnt_dn = 0;
    repeat (BC + 3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule